// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It turns raw request lines into pending bits, hides the pending bits that the mask register blocks, and keeps a record of which lines are being serviced. A rotating priority scheme picks the winning line. One interrupt output is raised whenever a pending, unmasked line outranks everything currently in service. Bus register decoding and vector generation are handled by the logic around it.

Each line is either edge-triggered or level-triggered, chosen per line. An acknowledge strobe moves the winning line into service, or into automatic completion when auto end-of-interrupt is on. End-of-interrupt strobes retire a serviced line. The retired line is either the highest-ranked one (non-specific) or a named one (specific), and either kind can move the rotation base. Special mask mode and the master's special fully nested mode change how the in-service level is worked out.

Top module: `irq_rot_core`

## Requirements
- R1: While `rst` is high, at the next clock edge the pending (`irr`), in-service (`isr`), mask, previous-level and rotation base (`rot_base`) registers all clear, and so `int_out` is low.
- R2: For an edge-mode line (`trig_level` bit = 0), the pending bit is set only at a clock where the input is 1 and was 0 at the previous clock. A falling input leaves the pending bit set.
- R3: For a level-mode line (`trig_level` bit = 1), the pending bit equals the input value sampled at the previous clock edge.
- R4: The candidates are `irr & ~mask`. Their rank is found by searching from line `rot_base` upward, modulo 8. The first set bit gives relative priority p, where 0 is highest. `win_line` = (p + `rot_base`) mod 8.
- R5: `int_out` is high only when the candidates' relative priority is strictly smaller than that of the highest-ranked in-service bit. An empty set counts as priority 8.
- R6: With `cfg_spec_mask` = 1, in-service bits of masked lines are left out of the in-service priority.
- R7: With `cfg_is_master` = 1 and `cfg_fully_nested` = 1, in-service bit 2 is left out of the in-service priority.
- R8: An `ack` while `int_out` is high and `cfg_auto_eoi` = 0 sets `isr[win_line]`. An `ack` while `int_out` is low changes no state.
- R9: An accepted `ack` with `cfg_auto_eoi` = 1 leaves `isr` unchanged. If `cfg_rot_auto` = 1 as well, `rot_base` becomes (`win_line` + 1) mod 8.
- R10: An accepted `ack` clears the winner's pending bit only for an edge-mode line. A new rising edge in the same cycle sets it again.
- R11: `eoi_valid` with `eoi_specific` = 0 clears the highest-ranked set `isr` bit, ranked from `rot_base` and ignoring the mask. With `eoi_rotate` = 1, `rot_base` becomes that line + 1 mod 8. When `isr` is empty the strobe has no effect.
- R12: `eoi_valid` with `eoi_specific` = 1 clears `isr[eoi_line]`. With `eoi_rotate` = 1, `rot_base` becomes `eoi_line` + 1 mod 8. An `ack` in the same cycle setting the same bit wins. An end-of-interrupt rotation takes precedence over an auto-EOI rotation.
- R13: `mask_we` loads `mask_val` into the mask register at the clock edge. A mask bit of 1 blocks that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Raw interrupt request lines |
| trig_level | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_val | input | 8 | New mask value, 1 = blocked |
| ack | input | 1 | Acknowledge strobe for the current winner |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_specific | input | 1 | 1 = retire `eoi_line`, 0 = retire the highest-ranked line |
| eoi_rotate | input | 1 | Move the rotation base past the retired line |
| eoi_line | input | 3 | Line index for a specific end-of-interrupt |
| cfg_auto_eoi | input | 1 | Acknowledge completes the interrupt automatically |
| cfg_rot_auto | input | 1 | Rotate on auto end-of-interrupt |
| cfg_spec_mask | input | 1 | Special mask mode |
| cfg_fully_nested | input | 1 | Special fully nested mode |
| cfg_is_master | input | 1 | Core acts as cascade master |
| int_out | output | 1 | Interrupt output |
| win_line | output | 3 | Current winning line (meaningful when `int_out` is high) |
| irr | output | 8 | Pending request register |
| isr | output | 8 | In-service register |
| rot_base | output | 3 | Rotation base, the line with highest priority |

## Verification
The hardest states to reach are those where a request is blocked only because something is already in service. One case is the in-service line being masked under special mask mode. Another is line 2 being in service on a master in fully nested mode. To get there, the bench first acknowledges a line to set its in-service bit. It then changes the mask or the mode and raises a lower-ranked request, so the exclusion rules decide the outcome. A sweep over every base and every candidate pattern covers priority ranking. A long random run with random acknowledge and end-of-interrupt strobes, checked against an arithmetic model, covers the interactions between those strobes.

// File: rtl/irq_rot_pkg.sv
package irq_rot_pkg;

    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);
    localparam int RW    = LW + 1;

    typedef logic [LINES-1:0] vec_t;
    typedef logic [LW-1:0]    idx_t;
    typedef logic [RW-1:0]    rel_t;

    localparam rel_t REL_NONE = rel_t'(LINES);

    typedef struct packed {
        logic auto_eoi;
        logic rot_auto;
        logic spec_mask;
        logic fully_nested;
        logic is_master;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic specific;
        logic rotate;
        idx_t line;
    } eoi_t;

    // Bit i of the result is bit (i + base) mod LINES of v.
    function automatic vec_t rot_to_base(vec_t v, idx_t base);
        vec_t r;
        for (int i = 0; i < LINES; i++) begin
            r[i] = v[idx_t'(idx_t'(i) + base)];
        end
        return r;
    endfunction

    function automatic vec_t onehot(idx_t k);
        vec_t r;
        r = '0;
        r[k] = 1'b1;
        return r;
    endfunction

    function automatic idx_t next_idx(idx_t k);
        return idx_t'(k + idx_t'(1));
    endfunction

endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find
    import irq_rot_pkg::*;
(
    input  vec_t bits,
    input  idx_t base,
    output rel_t rel,
    output idx_t line
);
    vec_t rotated;

    always_comb begin
        rotated = rot_to_base(bits, base);
        rel     = REL_NONE;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (rotated[i]) rel = rel_t'(i);
        end
        line = idx_t'(rel[LW-1:0] + base);
    end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture
    import irq_rot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t req_in,
    input  vec_t trig_level,
    input  vec_t ack_clr,
    output vec_t irr
);
    vec_t last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irr    <= '0;
            last_q <= '0;
        end else begin
            last_q <= req_in;
            for (int i = 0; i < LINES; i++) begin
                if (trig_level[i]) begin
                    irr[i] <= req_in[i];
                end else begin
                    irr[i] <= (irr[i] & ~ack_clr[i]) | (req_in[i] & ~last_q[i]);
                end
            end
        end
    end
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
    import irq_rot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  eoi_t eoi,
    input  logic ack_fire,
    input  idx_t win,
    input  logic top_valid,
    input  idx_t top_line,
    output vec_t isr,
    output idx_t base
);
    vec_t clr_vec;
    vec_t set_vec;
    logic eoi_hit;
    idx_t eoi_target;

    always_comb begin
        eoi_target = eoi.specific ? eoi.line : top_line;
        eoi_hit    = eoi.valid && (eoi.specific || top_valid);
        clr_vec    = eoi_hit ? onehot(eoi_target) : '0;
        set_vec    = (ack_fire && !cfg.auto_eoi) ? onehot(win) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr  <= '0;
            base <= '0;
        end else begin
            isr <= (isr & ~clr_vec) | set_vec;
            if (eoi_hit && eoi.rotate) begin
                base <= next_idx(eoi_target);
            end else if (ack_fire && cfg.auto_eoi && cfg.rot_auto) begin
                base <= next_idx(win);
            end
        end
    end
endmodule

// File: rtl/irq_rot_core.sv
module irq_rot_core
    import irq_rot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_in,
    input  logic [7:0] trig_level,
    input  logic       mask_we,
    input  logic [7:0] mask_val,
    input  logic       ack,
    input  logic       eoi_valid,
    input  logic       eoi_specific,
    input  logic       eoi_rotate,
    input  logic [2:0] eoi_line,
    input  logic       cfg_auto_eoi,
    input  logic       cfg_rot_auto,
    input  logic       cfg_spec_mask,
    input  logic       cfg_fully_nested,
    input  logic       cfg_is_master,
    output logic       int_out,
    output logic [2:0] win_line,
    output logic [7:0] irr,
    output logic [7:0] isr,
    output logic [2:0] rot_base
);
    localparam idx_t CASCADE_LINE = idx_t'(2);

    cfg_t cfg;
    eoi_t eoi;
    vec_t mask_q;
    vec_t cand;
    vec_t svc_view;
    vec_t ack_clr;
    rel_t cand_rel;
    rel_t svc_rel;
    rel_t top_rel;
    idx_t cand_line;
    idx_t svc_line;
    idx_t top_line;
    logic ack_fire;

    assign cfg = '{auto_eoi: cfg_auto_eoi, rot_auto: cfg_rot_auto,
                   spec_mask: cfg_spec_mask, fully_nested: cfg_fully_nested,
                   is_master: cfg_is_master};
    assign eoi = '{valid: eoi_valid, specific: eoi_specific,
                   rotate: eoi_rotate, line: eoi_line};

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_val;
    end

    always_comb begin
        cand     = irr & ~mask_q;
        svc_view = isr;
        if (cfg.spec_mask) svc_view = svc_view & ~mask_q;
        if (cfg.is_master && cfg.fully_nested) svc_view[CASCADE_LINE] = 1'b0;
    end

    irq_prio_find u_find_cand (.bits(cand),     .base(rot_base), .rel(cand_rel), .line(cand_line));
    irq_prio_find u_find_svc  (.bits(svc_view), .base(rot_base), .rel(svc_rel),  .line(svc_line));
    irq_prio_find u_find_top  (.bits(isr),      .base(rot_base), .rel(top_rel),  .line(top_line));

    assign int_out  = (cand_rel < svc_rel);
    assign win_line = cand_line;
    assign ack_fire = ack && int_out;
    assign ack_clr  = ack_fire ? (onehot(cand_line) & ~trig_level) : '0;

    irq_req_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .req_in    (req_in),
        .trig_level(trig_level),
        .ack_clr   (ack_clr),
        .irr       (irr)
    );

    irq_svc_tracker u_tracker (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .eoi      (eoi),
        .ack_fire (ack_fire),
        .win      (cand_line),
        .top_valid(top_rel != REL_NONE),
        .top_line (top_line),
        .isr      (isr),
        .base     (rot_base)
    );

    logic unused_svc;
    assign unused_svc = ^svc_line;
endmodule

// File: rtl/irq_rot_core_chk.sv
module irq_rot_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] req_in,
    input logic [7:0] trig_level,
    input logic       ack,
    input logic       eoi_valid,
    input logic       cfg_auto_eoi,
    input logic       cfg_rot_auto,
    input logic       int_out,
    input logic [2:0] win_line,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [2:0] rot_base,
    input logic [7:0] mask_q
);
    AST_INT_HAS_CAND: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~mask_q) != 8'h00)); // R5

    AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (irr[win_line] && !mask_q[win_line])); // R4

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((irr ^ $past(req_in)) & $past(trig_level)) == 8'h00)); // R3

    AST_ACK_SETS_SVC: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && !cfg_auto_eoi) |=> isr[$past(win_line)]); // R8

    AST_AUTO_EOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && cfg_auto_eoi && !eoi_valid) |=> $stable(isr)); // R9

    AST_AUTO_EOI_ROTATES: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && cfg_auto_eoi && cfg_rot_auto && !eoi_valid)
        |=> (rot_base == 3'($past(win_line) + 3'd1))); // R9

    AST_QUIET_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out && !eoi_valid) |=> $stable(isr) && $stable(rot_base)); // R8
endmodule

bind irq_rot_core irq_rot_core_chk u_chk (.*);

// File: tb/irq_rot_core_test.sv
`timescale 1ns/1ps
module irq_rot_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0, trig_level = '0, mask_val = '0;
    logic       mask_we = 0, ack = 0, eoi_valid = 0, eoi_specific = 0, eoi_rotate = 0;
    logic [2:0] eoi_line = '0;
    logic       cfg_auto_eoi = 0, cfg_rot_auto = 0, cfg_spec_mask = 0;
    logic       cfg_fully_nested = 0, cfg_is_master = 0;
    logic       int_out;
    logic [2:0] win_line, rot_base;
    logic [7:0] irr, isr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m_irr, m_isr, m_last, m_mask;
    int m_base;

    always #2.5 clk = ~clk;

    irq_rot_core uut (.*);

    function automatic int mpri(logic [7:0] m, int b);
        for (int p = 0; p < 8; p++) if (m[(p + b) % 8]) return p;
        return 8;
    endfunction

    function automatic int m_svc_rel();
        logic [7:0] v;
        v = m_isr;
        if (cfg_spec_mask) v = v & ~m_mask;
        if (cfg_is_master && cfg_fully_nested) v[2] = 1'b0;
        return mpri(v, m_base);
    endfunction

    function automatic bit m_int();
        return mpri(m_irr & ~m_mask, m_base) < m_svc_rel();
    endfunction

    function automatic int m_win();
        return (mpri(m_irr & ~m_mask, m_base) + m_base) % 8;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check({tag, " irr"}, irr, m_irr);
        check({tag, " isr"}, isr, m_isr);
        check({tag, " base"}, rot_base, m_base);
        check({tag, " int"}, int_out, m_int());
        if (m_int()) check({tag, " win"}, win_line, m_win());
    endtask

    // One clock: update model from pre-edge state and inputs, then compare.
    task automatic step(string tag);
        bit fire;
        int win, tgt;
        logic [7:0] n_irr, clr, set;
        fire = ack && m_int();
        win  = m_win();
        for (int i = 0; i < 8; i++) begin
            if (trig_level[i]) n_irr[i] = req_in[i];
            else n_irr[i] = (m_irr[i] & ~(fire && win == i)) | (req_in[i] & ~m_last[i]);
        end
        clr = '0; tgt = -1;
        if (eoi_valid) begin
            if (eoi_specific) tgt = eoi_line;
            else if (m_isr != 0) tgt = (mpri(m_isr, m_base) + m_base) % 8;
        end
        if (tgt >= 0) clr[tgt] = 1'b1;
        set = '0;
        if (fire && !cfg_auto_eoi) set[win] = 1'b1;
        @(posedge clk);
        m_last = req_in;
        m_irr  = n_irr;
        m_isr  = (m_isr & ~clr) | set;
        if (tgt >= 0 && eoi_rotate) m_base = (tgt + 1) % 8;
        else if (fire && cfg_auto_eoi && cfg_rot_auto) m_base = (win + 1) % 8;
        if (mask_we) m_mask = mask_val;
        #1;
        compare(tag);
    endtask

    task automatic idle();
        ack = 0; eoi_valid = 0; eoi_specific = 0; eoi_rotate = 0; mask_we = 0;
    endtask

    task automatic do_reset();
        rst = 1; idle();
        @(posedge clk); @(posedge clk); #1;
        m_irr = 0; m_isr = 0; m_last = 0; m_mask = 0; m_base = 0;
        rst = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        req_in = 8'hFF; trig_level = 8'hFF;
        do_reset();
        // R1: everything cleared by reset despite active inputs
        check("R1 irr", irr, 0); check("R1 isr", isr, 0);
        check("R1 base", rot_base, 0); check("R1 int", int_out, 0);
        req_in = 0; step("R3 level drop");
        check("R3 irr zero", irr, 0);

        // R2: edge line rise sets, fall keeps
        trig_level = 8'h00; req_in = 8'h10; step("R2 rise");
        check("R2 rise sets", irr[4], 1);
        req_in = 8'h00; step("R2 fall");
        check("R2 fall keeps", irr[4], 1);
        // R10: ack clears an edge line
        ack = 1; step("R10 ack edge"); idle();
        check("R10 edge cleared", irr[4], 0);
        check("R8 isr4 set", isr[4], 1);
        eoi_valid = 1; step("R11 nonspec"); idle();
        check("R11 isr empty", isr, 0);

        // R10: level line stays pending after ack
        trig_level = 8'h08; req_in = 8'h08; step("R3 level up");
        ack = 1; step("R10 ack level"); idle();
        check("R10 level kept", irr[3], 1);
        check("R8 isr3", isr, 8'h08);
        // R13 + R6: mask line 3; level line 1 not pending; lower line 5 request
        mask_we = 1; mask_val = 8'h08; req_in = 8'h28; trig_level = 8'h28;
        step("R13 mask load"); idle(); step("R13 settle");
        check("R6 blocked without special mask", int_out, 0);
        cfg_spec_mask = 1; #1; compare("R6 spec mask");
        check("R6 fires", int_out, 1);
        check("R6 win5", win_line, 5);
        cfg_spec_mask = 0;
        eoi_valid = 1; eoi_specific = 1; eoi_line = 3; step("R12 specific"); idle();
        check("R12 cleared", isr, 0);

        // R7: master fully nested ignores in-service line 2
        mask_we = 1; mask_val = 0; req_in = 8'h04; trig_level = 8'h04; step("R7 setup"); idle();
        ack = 1; step("R7 ack2"); idle();
        check("R7 isr2", isr, 8'h04);
        check("R7 no refire plain", int_out, 0);
        cfg_is_master = 1; cfg_fully_nested = 1; #1; compare("R7 nested");
        check("R7 refires", int_out, 1);
        cfg_is_master = 0; #1; compare("R7 slave role");
        check("R7 slave no refire", int_out, 0);
        cfg_fully_nested = 0;

        // R9: auto-EOI with rotation
        eoi_valid = 1; eoi_specific = 1; eoi_line = 2; step("R12 clear2"); idle();
        cfg_auto_eoi = 1; cfg_rot_auto = 1; ack = 1; step("R9 auto"); idle();
        check("R9 isr untouched", isr, 0);
        check("R9 base", rot_base, 3);
        cfg_auto_eoi = 0; cfg_rot_auto = 0;

        // R4/R5: sweep every base and every candidate pattern (level lines)
        do_reset();
        trig_level = 8'hFF;
        for (int b = 0; b < 8; b++) begin
            eoi_valid = 1; eoi_specific = 1; eoi_rotate = 1; eoi_line = 3'((b + 7) % 8);
            req_in = 0; step("R12 set base"); idle();
            check("R12 base", rot_base, b);
            for (int p = 0; p < 256; p++) begin
                req_in = 8'(p); step("R4 sweep");
            end
        end

        // R11 rotate: highest-ranked in-service line retired and base moves
        do_reset();
        trig_level = 8'hFF; req_in = 8'h60; step("R11 setup");
        ack = 1; step("R11 ack6"); idle();  // wins line 5 first
        ack = 1; eoi_valid = 0; req_in = 8'h40; step("R11 try"); idle();
        eoi_valid = 1; eoi_rotate = 1; step("R11 rotate"); idle();
        check("R11 base after rotate", rot_base, 6);

        // Mixed random run against the model (R2..R13)
        do_reset();
        for (int n = 0; n < 6000; n++) begin
            req_in       = 8'($urandom);
            if (n % 64 == 0) trig_level = 8'($urandom);
            mask_we      = ($urandom % 16) == 0;
            mask_val     = 8'($urandom) & 8'($urandom);
            ack          = ($urandom % 3) == 0;
            eoi_valid    = ($urandom % 4) == 0;
            eoi_specific = $urandom % 2;
            eoi_rotate   = $urandom % 2;
            eoi_line     = 3'($urandom);
            if (n % 200 == 0) begin
                cfg_auto_eoi     = ($urandom % 3) == 0;
                cfg_rot_auto     = $urandom % 2;
                cfg_spec_mask    = $urandom % 2;
                cfg_fully_nested = $urandom % 2;
                cfg_is_master    = $urandom % 2;
            end
            step("R2-mix random");
        end
        idle();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule